// File: doc/BRIEF.md
# Age-Ordered Wait/Ready Issue Queue

This block holds instructions that have been dispatched into an out-of-order back end until they issue and finish. Each instruction carries an index that grows by one per instruction and wraps at the index width. Each instruction also carries an execution class. Every occupied slot is in one of three states. An available slot waits for operands or for memory ordering. A ready slot may be picked. An executing slot has issued and waits for write-back.

A dispatch stage first reads `canDispatch`. When it presents an instruction while the queue is full, `dispStall` is raised and the instruction is dropped. A dispatched instruction whose operands and memory ordering are already satisfied becomes ready straight away. Any other dispatched instruction waits. Separate wakeup ports name the index whose register operands have arrived and the index whose memory dependencies have cleared. Each cycle the block first promotes every waiting entry that has both conditions met. It then picks, among the ready and just-promoted entries whose class has its resource available, the one with the oldest index. The pick appears on a registered issue port.

A write-back strobe that names an executing index frees that slot and raises a registered completion notification. Choosing execution units and ordering loads and stores happen outside the block. They reach it only as the `resAvail` vector and the memory-clear port.

Top module: `age_issue_queue`

## Requirements
- R1: After reset all slots are empty: `canDispatch`=1, `issueValid`=0, `doneValid`=0, `dispStall`=0.
- R2: An instruction dispatched with both `dispOps` and `dispMem` set is taken at clock edge k. If nothing older is eligible, it appears on `issueValid`/`issueIdx`/`issueCls` just after edge k+1.
- R3: An instruction dispatched without `dispOps` is not issued until a wakeup arrives. The wakeup is `wakeValid` with `wakeIdx` equal to its index. If the wakeup is captured at edge m and memory is already clear, the instruction is issued just after edge m+1.
- R4: An instruction dispatched without `dispMem` is not issued until `memValid` with a matching `memIdx` has been captured, even when its operands are ready. It is issued one edge after that capture.
- R5: Among eligible entries, the one with the oldest index is issued. Index a is older than b when (a−b) modulo 2^IDXW has its top bit set, so ordering survives wraparound. This holds as long as live indices lie within half the index range. Slot position does not affect the choice.
- R6: An entry of class c is eligible only when `resAvail[c]`=1 in the selecting cycle. A younger entry whose resource is available is issued ahead of an older blocked one.
- R7: At most one instruction is issued per cycle, and each dispatched instruction is issued exactly once.
- R8: `wbValid` with `wbIdx` equal to an executing entry's index frees that slot at the edge. `doneValid`=1 and `doneIdx`=`wbIdx` then appear just after that same edge. A write-back naming no executing entry is ignored (`doneValid` stays 0).
- R9: When all DEPTH slots are occupied, `canDispatch`=0. A dispatch presented then is dropped and never issues. A freed slot raises `canDispatch` after the freeing edge.
- R10: `dispStall` is 1 exactly when `dispValid`=1 and `canDispatch`=0, in the same cycle, with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| dispValid | input | 1 | Dispatch request |
| dispIdx | input | IDXW | Index of the dispatched instruction |
| dispOps | input | 1 | Register operands already available |
| dispMem | input | 1 | Memory dependencies already met |
| dispCls | input | CLSW | Execution class of the instruction |
| canDispatch | output | 1 | A free slot exists |
| dispStall | output | 1 | Dispatch refused this cycle |
| wakeValid | input | 1 | Operand wakeup strobe |
| wakeIdx | input | IDXW | Index whose operands are now available |
| memValid | input | 1 | Memory-clear strobe |
| memIdx | input | IDXW | Index whose memory dependencies are met |
| resAvail | input | 2^CLSW | Per-class resource availability |
| issueValid | output | 1 | An instruction was issued |
| issueIdx | output | IDXW | Index of the issued instruction |
| issueCls | output | CLSW | Class of the issued instruction |
| wbValid | input | 1 | Write-back strobe |
| wbIdx | input | IDXW | Index reaching write-back |
| doneValid | output | 1 | Completion notification |
| doneIdx | output | IDXW | Index that completed |

## Verification
Each fault in the slot states shows up at the issue or completion port within one or two edges.

- A wrong state, for example a waiting slot counted as ready, shows as an early `issueValid` one edge after dispatch or wakeup.
- A slot that never leaves the available state shows as an issue that never comes.
- A faulty age comparison appears as the wrong `issueIdx` as soon as two entries with wrapped indices are eligible together.
- A slot that is never freed shows as `canDispatch` staying low after the write-back edge.
- A slot freed twice or taken twice shows as a repeated index on the issue or completion port.

// File: rtl/iqsched_pkg.sv
package iqsched_pkg;
  // Width of slot numbers carried in the strobe bundle (allows up to 256 slots).
  localparam int unsigned SLOT_BITS = 8;

  typedef enum logic [1:0] {
    ST_FREE  = 2'd0,
    ST_AVAIL = 2'd1,
    ST_READY = 2'd2,
    ST_EXEC  = 2'd3
  } entState_t;

  // Control-to-datapath strobe bundle: at most one alloc, issue and retire per cycle.
  typedef struct packed {
    logic                 alloc;
    logic                 allocReady;
    logic [SLOT_BITS-1:0] allocSlot;
    logic                 issue;
    logic [SLOT_BITS-1:0] issueSlot;
    logic                 retire;
    logic [SLOT_BITS-1:0] retireSlot;
  } iqStrobes_t;
endpackage

// File: rtl/iqsched_store.sv
module iqsched_store
  import iqsched_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned IDXW  = 6,
  parameter int unsigned CLSW  = 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  iqStrobes_t                  strobes,
  input  logic [IDXW-1:0]             dispIdx,
  input  logic [CLSW-1:0]             dispCls,
  input  logic                        dispOps,
  input  logic                        dispMem,
  input  logic                        wakeValid,
  input  logic [IDXW-1:0]             wakeIdx,
  input  logic                        memValid,
  input  logic [IDXW-1:0]             memIdx,
  output logic [DEPTH-1:0]            freeVec,
  output logic [DEPTH-1:0]            readyVec,
  output logic [DEPTH-1:0]            promoVec,
  output logic [DEPTH-1:0]            execVec,
  output logic [DEPTH-1:0][IDXW-1:0]  entIdx,
  output logic [DEPTH-1:0][CLSW-1:0]  entCls
);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    entState_t       st;
    logic [IDXW-1:0] idxQ;
    logic [CLSW-1:0] clsQ;
    logic            opsQ;
    logic            memQ;
    logic            allocHit;
    logic            issueHit;
    logic            retireHit;
    logic            canPromote;

    assign allocHit   = strobes.alloc  && (strobes.allocSlot  == SLOT_BITS'(g));
    assign issueHit   = strobes.issue  && (strobes.issueSlot  == SLOT_BITS'(g));
    assign retireHit  = strobes.retire && (strobes.retireSlot == SLOT_BITS'(g));
    assign canPromote = (st == ST_AVAIL) && opsQ && memQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        st   <= ST_FREE;
        idxQ <= '0;
        clsQ <= '0;
        opsQ <= 1'b0;
        memQ <= 1'b0;
      end else if (allocHit) begin
        st   <= strobes.allocReady ? ST_READY : ST_AVAIL;
        idxQ <= dispIdx;
        clsQ <= dispCls;
        opsQ <= dispOps;
        memQ <= dispMem;
      end else if (issueHit) begin
        st <= ST_EXEC;
      end else if (retireHit) begin
        st <= ST_FREE;
      end else begin
        if (canPromote) st <= ST_READY;
        if (wakeValid && (st == ST_AVAIL) && (idxQ == wakeIdx)) opsQ <= 1'b1;
        if (memValid  && (st == ST_AVAIL) && (idxQ == memIdx))  memQ <= 1'b1;
      end
    end

    assign freeVec[g]  = (st == ST_FREE);
    assign readyVec[g] = (st == ST_READY);
    assign promoVec[g] = canPromote;
    assign execVec[g]  = (st == ST_EXEC);
    assign entIdx[g]   = idxQ;
    assign entCls[g]   = clsQ;

    // R9: a new instruction lands only in an empty slot
    p_alloc_free_r9: assert property (@(posedge clk) disable iff (!rstN)
      allocHit |-> (st == ST_FREE));
    // R3/R5: only a ready or promotable slot may be picked
    p_issue_eligible_r5: assert property (@(posedge clk) disable iff (!rstN)
      issueHit |-> ((st == ST_READY) || canPromote));
    // R8: only an executing slot is freed by write-back
    p_retire_exec_r8: assert property (@(posedge clk) disable iff (!rstN)
      retireHit |-> (st == ST_EXEC));
  end

endmodule

// File: rtl/iqsched_age_pick.sv
module iqsched_age_pick #(
  parameter int unsigned N    = 8,
  parameter int unsigned IDXW = 6
) (
  input  logic [N-1:0]            cand,
  input  logic [N-1:0][IDXW-1:0]  idxs,
  output logic [N-1:0]            winVec
);

  // Entry i wins when it is a candidate and older than every other candidate.
  // Older: the modular difference idx[i]-idx[j] is negative.
  logic [IDXW-1:0] diff;

  always_comb begin
    diff   = '0;
    winVec = cand;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        if ((i != j) && cand[j]) begin
          diff = idxs[i] - idxs[j];
          if (!diff[IDXW-1]) winVec[i] = 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/iqsched_ctrl.sv
module iqsched_ctrl
  import iqsched_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned IDXW  = 6,
  parameter int unsigned CLSW  = 1,
  localparam int unsigned NCLS = 1 << CLSW
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        dispValid,
  input  logic                        dispOps,
  input  logic                        dispMem,
  input  logic [NCLS-1:0]             resAvail,
  input  logic                        wbValid,
  input  logic [IDXW-1:0]             wbIdx,
  input  logic [DEPTH-1:0]            freeVec,
  input  logic [DEPTH-1:0]            readyVec,
  input  logic [DEPTH-1:0]            promoVec,
  input  logic [DEPTH-1:0]            execVec,
  input  logic [DEPTH-1:0][IDXW-1:0]  entIdx,
  input  logic [DEPTH-1:0][CLSW-1:0]  entCls,
  output iqStrobes_t                  strobes,
  output logic                        canDispatch,
  output logic                        dispStall,
  output logic                        issueValid,
  output logic [IDXW-1:0]             issueIdx,
  output logic [CLSW-1:0]             issueCls,
  output logic                        doneValid,
  output logic [IDXW-1:0]             doneIdx
);

  logic [DEPTH-1:0]     resOk;
  logic [DEPTH-1:0]     cand;
  logic [DEPTH-1:0]     winVec;
  logic [DEPTH-1:0]     wbHit;
  logic [SLOT_BITS-1:0] freeSlot;
  logic [SLOT_BITS-1:0] pickSlot;
  logic [SLOT_BITS-1:0] wbSlot;
  logic [IDXW-1:0]      pickIdx;
  logic [CLSW-1:0]      pickCls;

  assign canDispatch = |freeVec;
  assign dispStall   = dispValid && !canDispatch;

  for (genvar g = 0; g < DEPTH; g++) begin : g_elig
    assign resOk[g] = resAvail[entCls[g]];
    assign cand[g]  = (readyVec[g] || promoVec[g]) && resOk[g];
    assign wbHit[g] = wbValid && execVec[g] && (entIdx[g] == wbIdx);
  end

  iqsched_age_pick #(.N(DEPTH), .IDXW(IDXW)) u_pick (
    .cand   (cand),
    .idxs   (entIdx),
    .winVec (winVec)
  );

  // Lowest free slot, pick encoding and write-back match encoding.
  always_comb begin
    freeSlot = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (freeVec[i]) freeSlot = SLOT_BITS'(i);
    end
    pickSlot = '0;
    pickIdx  = '0;
    pickCls  = '0;
    wbSlot   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (winVec[i]) begin
        pickSlot = SLOT_BITS'(i);
        pickIdx  = entIdx[i];
        pickCls  = entCls[i];
      end
      if (wbHit[i]) wbSlot = SLOT_BITS'(i);
    end
  end

  always_comb begin
    strobes            = '0;
    strobes.alloc      = dispValid && canDispatch;
    strobes.allocReady = dispOps && dispMem;
    strobes.allocSlot  = freeSlot;
    strobes.issue      = |winVec;
    strobes.issueSlot  = pickSlot;
    strobes.retire     = |wbHit;
    strobes.retireSlot = wbSlot;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      issueValid <= 1'b0;
      issueIdx   <= '0;
      issueCls   <= '0;
      doneValid  <= 1'b0;
      doneIdx    <= '0;
    end else begin
      issueValid <= |winVec;
      issueIdx   <= pickIdx;
      issueCls   <= pickCls;
      doneValid  <= |wbHit;
      doneIdx    <= wbIdx;
    end
  end

  // R7: the age picker never names two winners
  p_single_pick_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(winVec));
  // R7: back-to-back issues carry different indices
  p_issue_unique_r7: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && $past(issueValid)) |=> (issueIdx != $past(issueIdx)) || !issueValid);
  // R6: an issued class had its resource available in the selecting cycle
  p_res_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.issue |=> (issueValid && $past(resAvail[pickCls])));
  // R8: a completion is always preceded by a write-back strobe
  p_done_needs_wb_r8: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> $past(wbValid));

endmodule

// File: rtl/age_issue_queue.sv
module age_issue_queue
  import iqsched_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned IDXW  = 6,
  parameter int unsigned CLSW  = 1,
  localparam int unsigned NCLS = 1 << CLSW
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dispValid,
  input  logic [IDXW-1:0]  dispIdx,
  input  logic             dispOps,
  input  logic             dispMem,
  input  logic [CLSW-1:0]  dispCls,
  output logic             canDispatch,
  output logic             dispStall,
  input  logic             wakeValid,
  input  logic [IDXW-1:0]  wakeIdx,
  input  logic             memValid,
  input  logic [IDXW-1:0]  memIdx,
  input  logic [NCLS-1:0]  resAvail,
  output logic             issueValid,
  output logic [IDXW-1:0]  issueIdx,
  output logic [CLSW-1:0]  issueCls,
  input  logic             wbValid,
  input  logic [IDXW-1:0]  wbIdx,
  output logic             doneValid,
  output logic [IDXW-1:0]  doneIdx
);

  iqStrobes_t                 strobes;
  logic [DEPTH-1:0]           freeVec;
  logic [DEPTH-1:0]           readyVec;
  logic [DEPTH-1:0]           promoVec;
  logic [DEPTH-1:0]           execVec;
  logic [DEPTH-1:0][IDXW-1:0] entIdx;
  logic [DEPTH-1:0][CLSW-1:0] entCls;

  iqsched_store #(.DEPTH(DEPTH), .IDXW(IDXW), .CLSW(CLSW)) u_store (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .dispIdx   (dispIdx),
    .dispCls   (dispCls),
    .dispOps   (dispOps),
    .dispMem   (dispMem),
    .wakeValid (wakeValid),
    .wakeIdx   (wakeIdx),
    .memValid  (memValid),
    .memIdx    (memIdx),
    .freeVec   (freeVec),
    .readyVec  (readyVec),
    .promoVec  (promoVec),
    .execVec   (execVec),
    .entIdx    (entIdx),
    .entCls    (entCls)
  );

  iqsched_ctrl #(.DEPTH(DEPTH), .IDXW(IDXW), .CLSW(CLSW)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .dispValid   (dispValid),
    .dispOps     (dispOps),
    .dispMem     (dispMem),
    .resAvail    (resAvail),
    .wbValid     (wbValid),
    .wbIdx       (wbIdx),
    .freeVec     (freeVec),
    .readyVec    (readyVec),
    .promoVec    (promoVec),
    .execVec     (execVec),
    .entIdx      (entIdx),
    .entCls      (entCls),
    .strobes     (strobes),
    .canDispatch (canDispatch),
    .dispStall   (dispStall),
    .issueValid  (issueValid),
    .issueIdx    (issueIdx),
    .issueCls    (issueCls),
    .doneValid   (doneValid),
    .doneIdx     (doneIdx)
  );

  // R10: a stall is flagged only for a presented dispatch
  p_stall_needs_req_r10: assert property (@(posedge clk) disable iff (!rstN)
    dispStall |-> dispValid);

endmodule

// File: tb/age_issue_queue_test.sv
module age_issue_queue_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       dispValid = 1'b0;
  logic [5:0] dispIdx = '0;
  logic       dispOps = 1'b0;
  logic       dispMem = 1'b0;
  logic [0:0] dispCls = '0;
  logic       canDispatch;
  logic       dispStall;
  logic       wakeValid = 1'b0;
  logic [5:0] wakeIdx = '0;
  logic       memValid = 1'b0;
  logic [5:0] memIdx = '0;
  logic [1:0] resAvail = 2'b11;
  logic       issueValid;
  logic [5:0] issueIdx;
  logic [0:0] issueCls;
  logic       wbValid = 1'b0;
  logic [5:0] wbIdx = '0;
  logic       doneValid;
  logic [5:0] doneIdx;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  age_issue_queue uut (
    .clk(clk), .rstN(rstN),
    .dispValid(dispValid), .dispIdx(dispIdx), .dispOps(dispOps), .dispMem(dispMem),
    .dispCls(dispCls), .canDispatch(canDispatch), .dispStall(dispStall),
    .wakeValid(wakeValid), .wakeIdx(wakeIdx), .memValid(memValid), .memIdx(memIdx),
    .resAvail(resAvail), .issueValid(issueValid), .issueIdx(issueIdx), .issueCls(issueCls),
    .wbValid(wbValid), .wbIdx(wbIdx), .doneValid(doneValid), .doneIdx(doneIdx)
  );

  typedef struct packed {
    logic       dv;  logic [5:0] di; logic dops; logic dmem; logic dcls;
    logic       wv;  logic [5:0] wi;
    logic       mv;  logic [5:0] mi;
    logic [1:0] res;
    logic       bv;  logic [5:0] bi;
    logic       eiv; logic [5:0] eii;
    logic       edv; logic [5:0] edi;
    logic       ecan;
    logic [3:0] rq;
  } vec_t;

  // dv di ops mem cls | wv wi | mv mi | res | bv bi | expIssue | expDone | expCan | req
  localparam vec_t VECS [28] = '{
    '{1'b1, 6'd5,  1'b1, 1'b1, 1'b0, 1'b0, 6'd0, 1'b0, 6'd0, 2'b11, 1'b0, 6'd0,  1'b0, 6'd0,  1'b0, 6'd0,  1'b1, 4'd2}, // R2 dispatch ready
    '{1'b1, 6'd6,  1'b0, 1'b1, 1'b0, 1'b0, 6'd0, 1'b0, 6'd0, 2'b11, 1'b0, 6'd0,  1'b1, 6'd5,  1'b0, 6'd0,  1'b1, 4'd2}, // R2 5 issues
    '{1'b1, 6'd7,  1'b1, 1'b0, 1'b1, 1'b0, 6'd0, 1'b0, 6'd0, 2'b11, 1'b0, 6'd0,  1'b0, 6'd0,  1'b0, 6'd0,  1'b1, 4'd3}, // R3 6 waits
    '{1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 1'b1, 6'd6, 1'b0, 6'd0, 2'b11, 1'b0, 6'd0,  1'b0, 6'd0,  1'b0, 6'd0,  1'b1, 4'd3}, // R3 wake 6
    '{1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 1'b0, 6'd0, 1'b1, 6'd7, 2'b11, 1'b0, 6'd0,  1'b1, 6'd6,  1'b0, 6'd0,  1'b1, 4'd3}, // R3 6 issues
    '{1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 1'b0, 6'd0, 1'b0, 6'd0, 2'b11, 1'b0, 6'd0,  1'b1, 6'd7,  1'b0, 6'd0,  1'b1, 4'd4}, // R4 7 after mem
    '{1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 1'b0, 6'd0, 1'b0, 6'd0, 2'b11, 1'b1, 6'd5,  1'b0, 6'd0,  1'b1, 6'd5,  1'b1, 4'd8}, // R8 wb 5
    '{1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 1'b0, 6'd0, 1'b0, 6'd0, 2'b11, 1'b1, 6'd9,  1'b0, 6'd0,  1'b0, 6'd0,  1'b1, 4'd8}, // R8 wb unknown
    '{1'b1, 6'd10, 1'b1, 1'b1, 1'b1, 1'b0, 6'd0, 1'b0, 6'd0, 2'b01, 1'b0, 6'd0,  1'b0, 6'd0,  1'b0, 6'd0,  1'b1, 4'd6},
    '{1'b1, 6'd11, 1'b1, 1'b1, 1'b0, 1'b0, 6'd0, 1'b0, 6'd0, 2'b01, 1'b0, 6'd0,  1'b0, 6'd0,  1'b0, 6'd0,  1'b1, 4'd6}, // R6 10 blocked
    '{1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 1'b0, 6'd0, 1'b0, 6'd0, 2'b01, 1'b0, 6'd0,  1'b1, 6'd11, 1'b0, 6'd0,  1'b1, 4'd6}, // R6 bypass
    '{1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 1'b0, 6'd0, 1'b0, 6'd0, 2'b11, 1'b0, 6'd0,  1'b1, 6'd10, 1'b0, 6'd0,  1'b1, 4'd6},
    '{1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 1'b0, 6'd0, 1'b0, 6'd0, 2'b11, 1'b1, 6'd6,  1'b0, 6'd0,  1'b1, 6'd6,  1'b1, 4'd8},
    '{1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 1'b0, 6'd0, 1'b0, 6'd0, 2'b11, 1'b1, 6'd7,  1'b0, 6'd0,  1'b1, 6'd7,  1'b1, 4'd8},
    '{1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 1'b0, 6'd0, 1'b0, 6'd0, 2'b11, 1'b1, 6'd11, 1'b0, 6'd0,  1'b1, 6'd11, 1'b1, 4'd8},
    '{1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 1'b0, 6'd0, 1'b0, 6'd0, 2'b11, 1'b1, 6'd10, 1'b0, 6'd0,  1'b1, 6'd10, 1'b1, 4'd8},
    '{1'b1, 6'd1,  1'b1, 1'b1, 1'b0, 1'b0, 6'd0, 1'b0, 6'd0, 2'b00, 1'b0, 6'd0,  1'b0, 6'd0,  1'b0, 6'd0,  1'b1, 4'd5}, // R5 reverse order
    '{1'b1, 6'd0,  1'b1, 1'b1, 1'b0, 1'b0, 6'd0, 1'b0, 6'd0, 2'b00, 1'b0, 6'd0,  1'b0, 6'd0,  1'b0, 6'd0,  1'b1, 4'd5},
    '{1'b1, 6'd63, 1'b1, 1'b1, 1'b0, 1'b0, 6'd0, 1'b0, 6'd0, 2'b00, 1'b0, 6'd0,  1'b0, 6'd0,  1'b0, 6'd0,  1'b1, 4'd5},
    '{1'b1, 6'd62, 1'b1, 1'b1, 1'b0, 1'b0, 6'd0, 1'b0, 6'd0, 2'b00, 1'b0, 6'd0,  1'b0, 6'd0,  1'b0, 6'd0,  1'b1, 4'd5},
    '{1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 1'b0, 6'd0, 1'b0, 6'd0, 2'b11, 1'b0, 6'd0,  1'b1, 6'd62, 1'b0, 6'd0,  1'b1, 4'd5}, // R5 wrap oldest
    '{1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 1'b0, 6'd0, 1'b0, 6'd0, 2'b11, 1'b0, 6'd0,  1'b1, 6'd63, 1'b0, 6'd0,  1'b1, 4'd7}, // R7 one per cycle
    '{1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 1'b0, 6'd0, 1'b0, 6'd0, 2'b11, 1'b0, 6'd0,  1'b1, 6'd0,  1'b0, 6'd0,  1'b1, 4'd5},
    '{1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 1'b0, 6'd0, 1'b0, 6'd0, 2'b11, 1'b0, 6'd0,  1'b1, 6'd1,  1'b0, 6'd0,  1'b1, 4'd7},
    '{1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 1'b0, 6'd0, 1'b0, 6'd0, 2'b11, 1'b1, 6'd62, 1'b0, 6'd0,  1'b1, 6'd62, 1'b1, 4'd8},
    '{1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 1'b0, 6'd0, 1'b0, 6'd0, 2'b11, 1'b1, 6'd63, 1'b0, 6'd0,  1'b1, 6'd63, 1'b1, 4'd8},
    '{1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 1'b0, 6'd0, 1'b0, 6'd0, 2'b11, 1'b1, 6'd0,  1'b0, 6'd0,  1'b1, 6'd0,  1'b1, 4'd8},
    '{1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 1'b0, 6'd0, 1'b0, 6'd0, 2'b11, 1'b1, 6'd1,  1'b0, 6'd0,  1'b1, 6'd1,  1'b1, 4'd8}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    dispValid = 1'b0; dispOps = 1'b0; dispMem = 1'b0; dispCls = '0; dispIdx = '0;
    wakeValid = 1'b0; memValid = 1'b0; wbValid = 1'b0; resAvail = 2'b11;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    // R1 reset state
    chk("R1", "canDispatch", int'(canDispatch), 1);
    chk("R1", "issueValid", int'(issueValid), 0);
    chk("R1", "doneValid", int'(doneValid), 0);
    chk("R1", "dispStall", int'(dispStall), 0);

    for (int r = 0; r < 28; r++) begin
      dispValid = VECS[r].dv; dispIdx = VECS[r].di; dispOps = VECS[r].dops;
      dispMem = VECS[r].dmem; dispCls = VECS[r].dcls;
      wakeValid = VECS[r].wv; wakeIdx = VECS[r].wi;
      memValid = VECS[r].mv; memIdx = VECS[r].mi;
      resAvail = VECS[r].res; wbValid = VECS[r].bv; wbIdx = VECS[r].bi;
      tick();
      chk($sformatf("R%0d row%0d", VECS[r].rq, r), "issueValid", int'(issueValid), int'(VECS[r].eiv));
      if (VECS[r].eiv)
        chk($sformatf("R%0d row%0d", VECS[r].rq, r), "issueIdx", int'(issueIdx), int'(VECS[r].eii));
      chk($sformatf("R%0d row%0d", VECS[r].rq, r), "doneValid", int'(doneValid), int'(VECS[r].edv));
      if (VECS[r].edv)
        chk($sformatf("R%0d row%0d", VECS[r].rq, r), "doneIdx", int'(doneIdx), int'(VECS[r].edi));
      chk($sformatf("R%0d row%0d", VECS[r].rq, r), "canDispatch", int'(canDispatch), int'(VECS[r].ecan));
    end
    idle();

    // R9: fill all eight slots with waiting instructions 20..27
    for (int k = 0; k < 8; k++) begin
      dispValid = 1'b1; dispIdx = 6'(20 + k); dispOps = 1'b0; dispMem = 1'b1; dispCls = '0;
      tick();
    end
    idle();
    chk("R9", "canDispatch when full", int'(canDispatch), 0);

    // R10 / R9: a ready dispatch while full stalls and is dropped
    dispValid = 1'b1; dispIdx = 6'd28; dispOps = 1'b1; dispMem = 1'b1;
    #1;
    chk("R10", "dispStall with request", int'(dispStall), 1);
    tick();
    idle();
    #1;
    chk("R10", "dispStall without request", int'(dispStall), 0);
    chk("R9", "no issue after dropped dispatch", int'(issueValid), 0);
    tick();
    chk("R9", "dropped entry never issues", int'(issueValid), 0);

    // R3: wakeup of 20 while full, then issue one edge later
    wakeValid = 1'b1; wakeIdx = 6'd20;
    tick();
    idle();
    chk("R3", "no issue at wake edge", int'(issueValid), 0);
    tick();
    chk("R3", "issueValid after wake", int'(issueValid), 1);
    chk("R3", "issueIdx after wake", int'(issueIdx), 20);
    chk("R2", "issueCls", int'(issueCls), 0);

    // R8 / R9: write-back of 20 frees a slot
    wbValid = 1'b1; wbIdx = 6'd20;
    tick();
    idle();
    chk("R8", "doneValid", int'(doneValid), 1);
    chk("R8", "doneIdx", int'(doneIdx), 20);
    chk("R9", "canDispatch after free", int'(canDispatch), 1);
    tick();
    chk("R8", "doneValid drops", int'(doneValid), 0);

    finishRun();
  end

endmodule